// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the control front end of a 128K x 8 parallel flash. It samples the chip-enable, output-enable and write-enable strobes on a system clock, filters out short write pulses, and recognises the multi-write unlock sequences that start a byte program, a whole-array erase or a lockout of the boot region. Each accepted operation becomes a one-cycle request, with its address and data, on an abstract storage port. The decoder stays busy until that port answers with a done pulse.

While an operation is busy, reads return status instead of array data. Bit 7 is a polling bit and bit 6 inverts on every read. The decoder also has an identification mode in which two fixed addresses return a manufacturer code and a device code. The storage array is outside the block. It is addressed directly by the bus address, and its read data comes back on `array_rdata`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is idle. `busy`, `id_mode`, `lock_flag` and the three request outputs are 0, and `dout` follows `array_rdata`.
- R2: A write counts only when chip enable and write enable have both been low, without interruption, for at least MIN_LOW clocks. The write takes effect when that low period ends. A shorter pulse is ignored.
- R3: A write is ignored if output enable is low or `supply_low` is high while the write strobe is low.
- R4: Byte program is AA@0x5555, 55@0x2AAA, A0@0x5555, then a fourth write of data at the target address. It produces a one-cycle `prog_req` with `req_addr`/`req_data` equal to that fourth write. `busy` stays high until `op_done`.
- R5: Chip erase is AA@0x5555, 55@0x2AAA, 80@0x5555, AA@0x5555, 55@0x2AAA, 10@0x5555. It produces a one-cycle `erase_req` and makes the block busy.
- R6: The same prefix ending in 40@0x5555 produces `lock_req`. `lock_flag` goes to 1 on the following `op_done` and then stays 1 until reset.
- R7: Once `lock_flag` is 1, a program whose target address is below BOOT_LIMIT (0x02000) produces no request. A program to BOOT_LIMIT or above still does.
- R8: A write whose address or data differs from the expected pair at any step returns the tracker to idle. A later data write then starts nothing.
- R9: While `busy` is 1, every write is ignored, including complete command sequences.
- R10: While a program is busy, `dout[7]` is the complement of bit 7 of the programmed byte. During an erase or a lockout, `dout[7]` reads 0. `dout[5:0]` read 0 while busy. After `op_done`, `dout` returns array data.
- R11: While busy, `dout[6]` is 0 on the first read and inverts at the end of each read. A read is a period with chip enable and output enable low and write enable high.
- R12: AA@0x5555, 55@0x2AAA, 90@0x5555 enters identification mode. In that mode, address 0 reads MFR_CODE, address 1 reads DEV_CODE, and every other address reads `array_rdata`.
- R13: Identification mode is left either by a single write of F0 to any address from idle, or by AA@0x5555, 55@0x2AAA, F0@0x5555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| supply_low | input | 1 | High when the supply is too low to program |
| addr | input | 17 | Bus address |
| din | input | 8 | Bus write data |
| dout | output | 8 | Read data or busy status |
| array_rdata | input | 8 | Storage array data at `addr` |
| op_done | input | 1 | Storage port finished the current operation |
| prog_req | output | 1 | One-cycle byte program request |
| erase_req | output | 1 | One-cycle chip erase request |
| lock_req | output | 1 | One-cycle boot lockout request |
| req_addr | output | 17 | Address that goes with the request |
| req_data | output | 8 | Data that goes with the request |
| busy | output | 1 | An operation is in progress |
| id_mode | output | 1 | Identification mode is active |
| lock_flag | output | 1 | Boot region is locked |

## Verification
The bench builds the block with its default parameters: MIN_LOW of 2, two synchroniser stages, and BOOT_LIMIT of 0x02000. With MIN_LOW at 2, a one-clock write pulse is shown to be rejected while a two-clock pulse is accepted. With BOOT_LIMIT at 0x02000, programs to 0x01FFF and 0x02000 fall on either side of the lockout boundary. The codes 0xC5 and 0x3A are used so that identification reads cannot be confused with the array data the bench drives.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command constants for the flash command decoder.
package flash_cmd_pkg;
    localparam logic [16:0] UNLK_ADDR_A = 17'h05555;
    localparam logic [16:0] UNLK_ADDR_B = 17'h02AAA;
    localparam logic [7:0]  KEY_A       = 8'hAA;
    localparam logic [7:0]  KEY_B       = 8'h55;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_ERPFX   = 8'h80;
    localparam logic [7:0]  CMD_IDIN    = 8'h90;
    localparam logic [7:0]  CMD_IDOUT   = 8'hF0;
    localparam logic [7:0]  CMD_ERASE   = 8'h10;
    localparam logic [7:0]  CMD_LOCK    = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE, ST_UNLK1, ST_UNLK2, ST_PGM,
        ST_ERA3, ST_ERA4, ST_ERA5, ST_BUSY
    } trk_state_t;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE, OP_LOCK} op_kind_t;
endpackage

// File: rtl/bus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes the vector is quasi-static relative to its qualifying strobe.
module bus_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // Shift one stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/strobe_qual.sv
// Qualifies bus strobes. It emits a one-cycle write event when a write low
// period of at least MIN_LOW clocks ends without an inhibit, and a read-end
// event when a read period ends. Assumes addr/din are stable while strobes are low.
module strobe_qual #(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int STAGES  = 2,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_end
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LOW);

    logic [3:0]        ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              wr_act, wr_ok, rd_act, wr_act_q, rd_act_q;
    logic [CNT_W-1:0]  low_cnt;

    bus_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1110)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n, supply_low}), .q(ctl_s));
    bus_sync #(.W(ADDR_W), .STAGES(STAGES), .RST_VAL('0)) u_addr_sync (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s));
    bus_sync #(.W(DATA_W), .STAGES(STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(din_s));

    assign wr_act = !ctl_s[3] && !ctl_s[1];
    assign wr_ok  = ctl_s[2] && !ctl_s[0];
    assign rd_act = !ctl_s[3] && !ctl_s[2] && ctl_s[1];

    // Count uninhibited write-low clocks and capture the bus during them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            if (!wr_act || !wr_ok) low_cnt <= '0;
            else if (low_cnt < MIN_C) low_cnt <= low_cnt + 1'b1;
            if (wr_act && wr_ok) begin
                wr_addr <= addr_s;
                wr_data <= din_s;
            end
        end
    end

    assign wr_stb = wr_act_q && !wr_act && wr_ok && (low_cnt >= MIN_C);
    assign rd_end = rd_act_q && !rd_act;
endmodule

// File: rtl/cmd_tracker.sv
// Tracks unlock command sequences and issues program, erase and lockout
// requests. It holds the busy, identification-mode and lock flags.
// Assumes op_done arrives only while busy; it is ignored otherwise.
module cmd_tracker
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W     = 17,
    parameter int          DATA_W     = 8,
    parameter logic [ADDR_W-1:0] BOOT_LIMIT = 17'h02000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    output logic              prog_req,
    output logic              erase_req,
    output logic              lock_req,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              busy,
    output op_kind_t          op_kind,
    output logic              id_mode,
    output logic              lock_flag
);
    trk_state_t state;
    logic       hit_a, hit_b, at_a;

    assign at_a  = (wr_addr == ADDR_W'(UNLK_ADDR_A));
    assign hit_a = at_a && (wr_data == KEY_A);
    assign hit_b = (wr_addr == ADDR_W'(UNLK_ADDR_B)) && (wr_data == KEY_B);
    assign busy  = (state == ST_BUSY);

    // Advance the command sequence and manage requests and mode flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_kind   <= OP_NONE;
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            lock_req  <= 1'b0;
            req_addr  <= '0;
            req_data  <= '0;
            id_mode   <= 1'b0;
            lock_flag <= 1'b0;
        end else begin
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            lock_req  <= 1'b0;
            if (state == ST_BUSY) begin
                if (op_done) begin
                    state <= ST_IDLE;
                    if (op_kind == OP_LOCK) lock_flag <= 1'b1;
                    op_kind <= OP_NONE;
                end
            end else if (wr_stb) begin
                state <= ST_IDLE;
                case (state)
                    ST_IDLE: begin
                        if (hit_a) state <= ST_UNLK1;
                        else if (wr_data == CMD_IDOUT) id_mode <= 1'b0;
                    end
                    ST_UNLK1: if (hit_b) state <= ST_UNLK2;
                    ST_UNLK2: if (at_a) begin
                        case (wr_data)
                            CMD_PROG:  state <= ST_PGM;
                            CMD_ERPFX: state <= ST_ERA3;
                            CMD_IDIN:  id_mode <= 1'b1;
                            CMD_IDOUT: id_mode <= 1'b0;
                            default:   state <= ST_IDLE;
                        endcase
                    end
                    ST_PGM: if (!(lock_flag && (wr_addr < BOOT_LIMIT))) begin
                        state    <= ST_BUSY;
                        op_kind  <= OP_PROG;
                        prog_req <= 1'b1;
                        req_addr <= wr_addr;
                        req_data <= wr_data;
                    end
                    ST_ERA3: if (hit_a) state <= ST_ERA4;
                    ST_ERA4: if (hit_b) state <= ST_ERA5;
                    ST_ERA5: if (at_a && wr_data == CMD_ERASE) begin
                        state     <= ST_BUSY;
                        op_kind   <= OP_ERASE;
                        erase_req <= 1'b1;
                        req_addr  <= wr_addr;
                        req_data  <= wr_data;
                    end else if (at_a && wr_data == CMD_LOCK) begin
                        state    <= ST_BUSY;
                        op_kind  <= OP_LOCK;
                        lock_req <= 1'b1;
                        req_addr <= wr_addr;
                        req_data <= wr_data;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/status_gen.sv
// Selects read data. While busy it returns polling and toggle status; in
// identification mode it returns the codes at addresses 0 and 1; otherwise
// it returns array data.
module status_gen
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'hC5,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  op_kind_t          op_kind,
    input  logic              op_start,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rd_end,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] dout
);
    logic tgl;

    // Clear the toggle bit at operation start; invert it after each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n)              tgl <= 1'b0;
        else if (op_start)       tgl <= 1'b0;
        else if (busy && rd_end) tgl <= ~tgl;
    end

    // Choose status, identification code or array data.
    always_comb begin
        dout = array_rdata;
        if (busy) begin
            dout = '0;
            dout[DATA_W-1] = (op_kind == OP_PROG) ? ~req_data[DATA_W-1] : 1'b0;
            dout[DATA_W-2] = tgl;
        end else if (id_mode && addr == ADDR_W'(0)) begin
            dout = MFR_CODE;
        end else if (id_mode && addr == ADDR_W'(1)) begin
            dout = DEV_CODE;
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command decoder. It qualifies strobes, tracks command
// sequences and generates read status. The storage array sits outside and is
// addressed by the bus address directly.
module flash_cmd_ctrl #(
    parameter int          ADDR_W     = 17,
    parameter int          DATA_W     = 8,
    parameter int          STAGES     = 2,
    parameter int          MIN_LOW    = 2,
    parameter logic [16:0] BOOT_LIMIT = 17'h02000,
    parameter logic [7:0]  MFR_CODE   = 8'hC5,
    parameter logic [7:0]  DEV_CODE   = 8'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              op_done,
    output logic              prog_req,
    output logic              erase_req,
    output logic              lock_req,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              id_mode,
    output logic              lock_flag
);
    import flash_cmd_pkg::*;

    logic              wr_stb, rd_end;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    op_kind_t          op_kind;

    strobe_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES), .MIN_LOW(MIN_LOW)) u_qual (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_low(supply_low), .addr(addr), .din(din),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_end(rd_end));

    cmd_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_LIMIT(ADDR_W'(BOOT_LIMIT))) u_trk (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_done(op_done), .prog_req(prog_req), .erase_req(erase_req), .lock_req(lock_req),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .op_kind(op_kind),
        .id_mode(id_mode), .lock_flag(lock_flag));

    status_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .MFR_CODE(DATA_W'(MFR_CODE)), .DEV_CODE(DATA_W'(DEV_CODE))) u_stat (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_kind(op_kind),
        .op_start(prog_req | erase_req | lock_req), .req_data(req_data),
        .rd_end(rd_end), .id_mode(id_mode), .addr(addr),
        .array_rdata(array_rdata), .dout(dout));
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Property checker for flash_cmd_ctrl, attached through bind.
module flash_cmd_ctrl_chk #(
    parameter int          ADDR_W     = 17,
    parameter logic [16:0] BOOT_LIMIT = 17'h02000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_req,
    input logic              erase_req,
    input logic              lock_req,
    input logic [ADDR_W-1:0] req_addr,
    input logic              busy,
    input logic              lock_flag,
    input logic              op_done
);
    // R4: at most one request at a time
    assert_req_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req, lock_req}));
    // R4: a request lasts a single cycle
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_req || lock_req) |=> !(prog_req || erase_req || lock_req));
    // R4: busy stays high until op_done
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> busy);
    // R6: the lock flag never clears
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |=> lock_flag);
    // R7: no program request into the locked boot region
    assert_boot_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && lock_flag) |-> (req_addr >= ADDR_W'(BOOT_LIMIT)));
    // R9: no new request while an operation is already busy
    assert_no_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !(prog_req || erase_req || lock_req));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .BOOT_LIMIT(BOOT_LIMIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
    .lock_req(lock_req), .req_addr(req_addr), .busy(busy),
    .lock_flag(lock_flag), .op_done(op_done));

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0, array_rdata = 8'h33;
    logic        op_done = 1'b0;
    logic [7:0]  dout;
    logic        prog_req, erase_req, lock_req, busy, id_mode, lock_flag;
    logic [16:0] req_addr;
    logic [7:0]  req_data;

    int checks = 0, errors = 0;
    int n_prog = 0, n_erase = 0, n_lock = 0;
    logic [16:0] last_addr = '0;
    logic [7:0]  last_data = '0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_low(supply_low), .addr(addr), .din(din), .dout(dout),
        .array_rdata(array_rdata), .op_done(op_done), .prog_req(prog_req),
        .erase_req(erase_req), .lock_req(lock_req), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .id_mode(id_mode), .lock_flag(lock_flag));

    // Count request pulses and record the request payload.
    always @(posedge clk) begin
        if (prog_req)  begin n_prog++;  last_addr <= req_addr; last_data <= req_data; end
        if (erase_req) n_erase++;
        if (lock_req)  n_lock++;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [16:0] a, input logic [7:0] d,
                          input int low = 3, input logic oe = 1'b1, input logic sl = 1'b0);
        @(negedge clk);
        addr = a; din = d; oe_n = oe; supply_low = sl; ce_n = 1'b0; we_n = 1'b0;
        repeat (low) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (5) @(negedge clk);
        oe_n = 1'b1; supply_low = 1'b0;
    endtask

    task automatic bus_rd(input logic [16:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        d = dout;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic unlock(input logic [7:0] cmd);
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAA, 8'h55);
        bus_wr(17'h05555, cmd);
    endtask

    task automatic finish_op();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !id_mode && !lock_flag, "R1 flags", {busy, id_mode, lock_flag}, 0);
        chk(n_prog + n_erase + n_lock == 0, "R1 requests", n_prog + n_erase + n_lock, 0);
        chk(dout == array_rdata, "R1 dout", dout, array_rdata);
    endtask

    task automatic t_program();
        logic [7:0] r;
        int p0 = n_prog;
        unlock(8'hA0);
        bus_wr(17'h03000, 8'h5A);
        chk(n_prog == p0 + 1, "R4 prog_req count", n_prog, p0 + 1);
        chk(last_addr == 17'h03000 && last_data == 8'h5A, "R4 payload", {last_addr, last_data}, {17'h03000, 8'h5A});
        chk(busy, "R4 busy", busy, 1);
        bus_rd(17'h03000, r);
        chk(r == 8'h80, "R10 R11 first busy read", r, 8'h80);
        bus_rd(17'h03000, r);
        chk(r == 8'hC0, "R11 second busy read", r, 8'hC0);
        bus_rd(17'h03000, r);
        chk(r == 8'h80, "R11 third busy read", r, 8'h80);
        array_rdata = 8'h5A;
        finish_op();
        chk(!busy, "R4 busy clears", busy, 0);
        bus_rd(17'h03000, r);
        chk(r == 8'h5A, "R10 true data after done", r, 8'h5A);
    endtask

    task automatic t_busy_ignore();
        int p0;
        unlock(8'hA0);
        bus_wr(17'h04000, 8'h11);
        p0 = n_prog;
        unlock(8'hA0);
        bus_wr(17'h04001, 8'h22);
        chk(n_prog == p0, "R9 writes ignored while busy", n_prog, p0);
        chk(last_addr == 17'h04000, "R9 payload unchanged", last_addr, 17'h04000);
        finish_op();
    endtask

    task automatic t_glitch();
        int p0 = n_prog;
        unlock(8'hA0);
        bus_wr(17'h05000, 8'h33, 1);
        chk(n_prog == p0, "R2 one-clock pulse ignored", n_prog, p0);
        bus_wr(17'h05000, 8'h34, 2);
        chk(n_prog == p0 + 1, "R2 two-clock pulse accepted", n_prog, p0 + 1);
        chk(last_data == 8'h34, "R2 payload", last_data, 8'h34);
        finish_op();
    endtask

    task automatic t_inhibit();
        int p0 = n_prog;
        unlock(8'hA0);
        bus_wr(17'h06000, 8'h44, 3, 1'b0, 1'b0);
        chk(n_prog == p0, "R3 oe low inhibits", n_prog, p0);
        bus_wr(17'h06000, 8'h45, 3, 1'b1, 1'b1);
        chk(n_prog == p0, "R3 supply_low inhibits", n_prog, p0);
        bus_wr(17'h06000, 8'h46);
        chk(n_prog == p0 + 1 && last_data == 8'h46, "R3 clean write accepted", last_data, 8'h46);
        finish_op();
    endtask

    task automatic t_deviate();
        int p0 = n_prog;
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAA, 8'h55);
        bus_wr(17'h01234, 8'hA0);
        bus_wr(17'h03000, 8'h77);
        chk(n_prog == p0 && !busy, "R8 wrong third address", n_prog, p0);
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAA, 8'h54);
        bus_wr(17'h05555, 8'hA0);
        bus_wr(17'h03000, 8'h78);
        chk(n_prog == p0 && !busy, "R8 wrong second data", n_prog, p0);
    endtask

    task automatic t_erase();
        logic [7:0] r;
        int e0 = n_erase;
        unlock(8'h80);
        unlock(8'h10);
        chk(n_erase == e0 + 1 && busy, "R5 erase request", n_erase, e0 + 1);
        bus_rd(17'h00010, r);
        chk(r == 8'h00, "R10 R11 erase first read", r, 8'h00);
        bus_rd(17'h00010, r);
        chk(r == 8'h40, "R11 erase second read", r, 8'h40);
        finish_op();
        chk(!busy && !lock_flag, "R5 erase done, no lock", {busy, lock_flag}, 0);
    endtask

    task automatic t_id();
        logic [7:0] r;
        array_rdata = 8'h66;
        unlock(8'h90);
        chk(id_mode, "R12 entry", id_mode, 1);
        bus_rd(17'h00000, r); chk(r == 8'hC5, "R12 manufacturer code", r, 8'hC5);
        bus_rd(17'h00001, r); chk(r == 8'h3A, "R12 device code", r, 8'h3A);
        bus_rd(17'h00005, r); chk(r == 8'h66, "R12 other address", r, 8'h66);
        bus_wr(17'h1ABCD, 8'hF0);
        chk(!id_mode, "R13 single-write exit", id_mode, 0);
        bus_rd(17'h00000, r); chk(r == 8'h66, "R13 array after exit", r, 8'h66);
        unlock(8'h90);
        unlock(8'hF0);
        chk(!id_mode, "R13 three-write exit", id_mode, 0);
    endtask

    task automatic t_lock();
        int p0 = n_prog, l0 = n_lock;
        unlock(8'hA0);
        bus_wr(17'h00100, 8'h01);
        chk(n_prog == p0 + 1, "R7 boot program before lock", n_prog, p0 + 1);
        finish_op();
        unlock(8'h80);
        unlock(8'h40);
        chk(n_lock == l0 + 1 && !lock_flag, "R6 lock request, flag waits", {n_lock[7:0], lock_flag}, {8'(l0 + 1), 1'b0});
        finish_op();
        chk(lock_flag, "R6 lock flag set", lock_flag, 1);
        unlock(8'hA0);
        bus_wr(17'h01FFF, 8'h02);
        chk(n_prog == p0 + 1 && !busy, "R7 boot program blocked", n_prog, p0 + 1);
        unlock(8'hA0);
        bus_wr(17'h02000, 8'h03);
        chk(n_prog == p0 + 2, "R7 program at limit allowed", n_prog, p0 + 2);
        finish_op();
        chk(lock_flag, "R6 lock flag stays", lock_flag, 1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program();
        t_busy_ignore();
        t_glitch();
        t_inhibit();
        t_deviate();
        t_erase();
        t_id();
        t_lock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule